// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps track of an on-chip packet memory of 18 pages of 256 bytes each, and hands out packet numbers for frames stored in it. A host issues commands through a small command port. It can allocate a block of contiguous pages, free a chosen packet, release the packet at the head of the receive FIFO, queue a packet for transmission, or wipe the whole memory. An allocation takes several cycles, and a busy flag stays high while it runs. When it finishes, the block writes a result byte that holds either the granted packet number or a failure bit, and sets a sticky completion flag that can raise a maskable interrupt.

Three small FIFOs carry packet numbers between the host and the MAC. The transmit queue holds packets the host has marked for sending. The receive FIFO holds packets the MAC has filled. The completion FIFO holds transmissions that need host attention. When automatic release is on, a packet that transmits successfully gives its pages back with no host action. Any other transmit outcome goes into the completion FIFO and raises the transmit interrupt flag.

The host sizes a request as (frame length + 6) >> 8, which is the page count minus one. A request of 0 asks for one page.

Top module: `pkt_buf_alloc`

## Requirements
- R1: After reset the outputs are as follows: busy is 0, alloc_result is 0, irq_stat is 0, irq is 0, and txq_empty, rx_empty and done_empty are all 1. All pages are free.
- R2: Opcode 1 (allocate) with cmd_arg = N asks for N+1 contiguous pages. The block places them at the lowest start page where all N+1 pages are free. It grants the lowest unused packet number P and sets alloc_result = {1'b0, 2'b00, P[4:0]}. In the cycle busy falls, irq_stat[0] is 1.
- R3: If no free run of N+1 pages exists, the allocation fails. alloc_result is then 8'h80 (bit 7 is the failure flag, bits 4:0 are zero), no page changes state, and irq_stat[0] is still set.
- R4: A command is accepted only when cmd_valid is high and busy is low. busy is high in the cycle after a command with opcode 1 to 5 is accepted. Any command presented while busy is high is ignored.
- R5: irq_stat[0] stays set until irq_ack[0] is pulsed. The output irq equals the OR of (irq_stat & irq_mask).
- R6: Opcode 4 (free) returns the pages of packet sel_pnum and its packet number to the free pool. If sel_pnum is not allocated, the command has no effect.
- R7: Opcode 5 (enqueue) pushes sel_pnum into the transmit queue. txq_head shows the oldest entry when txq_empty is 0, and a txq_pop pulse removes it, so entries leave in arrival order.
- R8: A tx_done pulse that has both tx_ok and auto_rel high frees packet tx_done_pnum. Any other tx_done pulse pushes tx_done_pnum into the completion FIFO. irq_stat[1] equals !done_empty, and an irq_ack[1] pulse pops done_head.
- R9: Opcode 3 (release) frees the packet at rx_head and pops the receive FIFO. If the receive FIFO is empty, the command changes nothing.
- R10: Opcode 2 (reset) frees every page and packet number and empties all three FIFOs.
- R11: Each FIFO holds 8 entries. A push into a full FIFO is dropped, and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 1 allocate, 2 reset, 3 release, 4 free, 5 enqueue |
| cmd_arg | input | 5 | Page count minus one, for allocate |
| sel_pnum | input | 5 | Selected packet number, for free and enqueue |
| busy | output | 1 | A command is being executed |
| alloc_result | output | 8 | Bit 7 is the failure flag, bits 4:0 are the granted packet number |
| auto_rel | input | 1 | Free packets automatically after a successful transmit |
| irq_mask | input | 2 | Interrupt enables: bit 0 allocation, bit 1 transmit |
| irq_ack | input | 2 | Bit 0 clears the allocation flag, bit 1 pops the completion FIFO |
| irq_stat | output | 2 | Raw flags: bit 0 allocation done, bit 1 completion FIFO not empty |
| irq | output | 1 | Masked interrupt request |
| txq_empty | output | 1 | Transmit queue is empty |
| txq_head | output | 5 | Oldest packet in the transmit queue |
| txq_pop | input | 1 | The MAC takes the transmit queue head |
| tx_done | input | 1 | The MAC reports that a transmission has ended |
| tx_ok | input | 1 | The transmission succeeded |
| tx_done_pnum | input | 5 | Packet number of the finished transmission |
| done_empty | output | 1 | Completion FIFO is empty |
| done_head | output | 5 | Oldest entry in the completion FIFO |
| rx_push | input | 1 | The MAC stores a received packet number |
| rx_pnum | input | 5 | Received packet number |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_head | output | 5 | Oldest received packet number |

## Verification
Allocation is exercised with several request patterns, each chosen to separate one possible mistake:
- Single-page requests and requests that fit only past a hole. These tell a first-fit placer from one that takes the first free page, or one that ignores run length.
- Requests that are too large, and requests made when memory is full. These check the failure encoding, and check that a failed attempt leaves all pages unchanged.
- A free followed by a new allocation. This shows whether the lowest unused packet number is reused.
- A long run of random allocate, free, release, enqueue and transmit-done events, with auto-release switched on and off. This is compared against a page-level model and checks page accounting and FIFO order across every command.

// File: rtl/pba_pkg.sv
// Shared types of the paged packet buffer allocator.
// Assumes: opcode values are fixed by the host command port encoding.
package pba_pkg;
    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_WIPE    = 3'd2,
        OP_RELEASE = 3'd3,
        OP_FREE    = 3'd4,
        OP_ENQUEUE = 3'd5
    } pba_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HOLD
    } pba_state_e;
endpackage

// File: rtl/pba_fifo.sv
// Small synchronous FIFO of packet numbers.
// Does: one push and one pop per cycle, with a synchronous clear.
// Assumes: a push into a full FIFO and a pop from an empty FIFO are both dropped.
module pba_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write, done only when a push is accepted.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> $stable(cnt));
endmodule

// File: rtl/pba_page_map.sv
// Page occupancy bitmap, with a window test for first-fit search.
// Does: reports whether the window that starts at scan_start and is cnt_m1+1
//       pages long lies inside memory and is fully free; claims that window
//       on commit; frees up to two windows per cycle.
// Assumes: commit is raised only when win_ok is true.
module pba_page_map #(
    parameter int NUM_PAGES = 18,
    parameter int ARG_W     = 5,
    parameter int PAGE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PAGE_W-1:0] scan_start,
    input  logic [ARG_W-1:0]  cnt_m1,
    output logic              win_ok,
    input  logic              commit,
    input  logic              fa_en,
    input  logic [PAGE_W-1:0] fa_start,
    input  logic [ARG_W-1:0]  fa_cnt,
    input  logic              fb_en,
    input  logic [PAGE_W-1:0] fb_start,
    input  logic [ARG_W-1:0]  fb_cnt
);
    logic [NUM_PAGES-1:0] used, win_mask, free_mask;
    logic                 fits;

    function automatic logic [NUM_PAGES-1:0] span(input logic [PAGE_W-1:0] s,
                                                  input logic [ARG_W-1:0]  m1);
        logic [NUM_PAGES-1:0] m;
        for (int p = 0; p < NUM_PAGES; p++)
            m[p] = (p >= int'(s)) && (p <= int'(s) + int'(m1));
        return m;
    endfunction

    // Candidate window and the union of the windows being freed.
    always_comb begin
        win_mask  = span(scan_start, cnt_m1);
        fits      = (int'(scan_start) + int'(cnt_m1)) < NUM_PAGES;
        win_ok    = fits && ((used & win_mask) == '0);
        free_mask = (fa_en ? span(fa_start, fa_cnt) : '0)
                  | (fb_en ? span(fb_start, fb_cnt) : '0);
    end

    // Bitmap update: free first, then claim the committed window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) used <= '0;
        else               used <= (used & ~free_mask) | (commit ? win_mask : '0);
    end

    // R2
    claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((used & win_mask) == '0));
endmodule

// File: rtl/pba_pnum_table.sv
// Packet number table: per number, a valid bit, start page and length-1.
// Does: finds the lowest unused number; two lookup ports; one set port and
//       two clear ports per cycle.
// Assumes: set_idx is unused when set_en is raised.
module pba_pnum_table #(
    parameter int NPKT   = 32,
    parameter int PNUM_W = 5,
    parameter int PAGE_W = 5,
    parameter int ARG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic              any_free,
    output logic [PNUM_W-1:0] free_idx,
    input  logic [PNUM_W-1:0] a_idx,
    output logic              a_valid,
    output logic [PAGE_W-1:0] a_start,
    output logic [ARG_W-1:0]  a_cnt,
    input  logic [PNUM_W-1:0] b_idx,
    output logic              b_valid,
    output logic [PAGE_W-1:0] b_start,
    output logic [ARG_W-1:0]  b_cnt,
    input  logic              set_en,
    input  logic [PNUM_W-1:0] set_idx,
    input  logic [PAGE_W-1:0] set_start,
    input  logic [ARG_W-1:0]  set_cnt,
    input  logic              ca_en,
    input  logic              cb_en
);
    logic [NPKT-1:0]   valid;
    logic [PAGE_W-1:0] start_q [NPKT];
    logic [ARG_W-1:0]  cnt_q   [NPKT];

    assign a_valid = valid[a_idx];
    assign a_start = start_q[a_idx];
    assign a_cnt   = cnt_q[a_idx];
    assign b_valid = valid[b_idx];
    assign b_start = start_q[b_idx];
    assign b_cnt   = cnt_q[b_idx];

    // Lowest-numbered unused entry.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NPKT-1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = PNUM_W'(i);
            end
        end
    end

    // Location fields, written when an entry is granted.
    always_ff @(posedge clk) begin
        if (set_en) begin
            start_q[set_idx] <= set_start;
            cnt_q[set_idx]   <= set_cnt;
        end
    end

    // Valid bits: clears first, then the grant.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            valid <= '0;
        end else begin
            logic [NPKT-1:0] nv;
            nv = valid;
            if (ca_en)  nv[a_idx]   = 1'b0;
            if (cb_en)  nv[b_idx]   = 1'b0;
            if (set_en) nv[set_idx] = 1'b1;
            valid <= nv;
        end
    end

    // R2
    grant_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> valid[$past(set_idx)]);
endmodule

// File: rtl/pkt_buf_alloc.sv
// Paged packet buffer allocator, top level.
// Does: decodes host commands, runs a multi-cycle first-fit page search,
//       keeps interrupt flags and the transmit, receive and completion FIFOs.
// Assumes: the host waits for busy low before it issues the next command;
//          the MAC drives tx_done, txq_pop and rx_push as single-cycle pulses.
module pkt_buf_alloc
    import pba_pkg::*;
#(
    parameter int NUM_PAGES  = 18,
    parameter int NPKT       = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int ARG_W      = 5,
    parameter int RES_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [ARG_W-1:0]          cmd_arg,
    input  logic [$clog2(NPKT)-1:0]   sel_pnum,
    output logic                      busy,
    output logic [RES_W-1:0]          alloc_result,
    input  logic                      auto_rel,
    input  logic [1:0]                irq_mask,
    input  logic [1:0]                irq_ack,
    output logic [1:0]                irq_stat,
    output logic                      irq,
    output logic                      txq_empty,
    output logic [$clog2(NPKT)-1:0]   txq_head,
    input  logic                      txq_pop,
    input  logic                      tx_done,
    input  logic                      tx_ok,
    input  logic [$clog2(NPKT)-1:0]   tx_done_pnum,
    output logic                      done_empty,
    output logic [$clog2(NPKT)-1:0]   done_head,
    input  logic                      rx_push,
    input  logic [$clog2(NPKT)-1:0]   rx_pnum,
    output logic                      rx_empty,
    output logic [$clog2(NPKT)-1:0]   rx_head
);
    localparam int PNUM_W = $clog2(NPKT);
    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int PAD_W  = RES_W - 1 - PNUM_W;

    pba_state_e        state;
    pba_op_e           op;
    logic              accept, scan_done, commit, win_ok;
    logic [PAGE_W-1:0] scan_idx;
    logic [ARG_W-1:0]  req_m1;
    logic              alloc_flag;
    logic              wipe, host_free_req, auto_free_req, rx_pop, enq_push, done_push;
    logic              any_free;
    logic [PNUM_W-1:0] free_idx, a_idx;
    logic              a_valid, b_valid;
    logic [PAGE_W-1:0] a_start, b_start;
    logic [ARG_W-1:0]  a_cnt, b_cnt;

    assign op     = pba_op_e'(cmd_op);
    assign accept = cmd_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    // Host and MAC event decode.
    always_comb begin
        wipe          = accept && (op == OP_WIPE);
        rx_pop        = accept && (op == OP_RELEASE);
        enq_push      = accept && (op == OP_ENQUEUE);
        host_free_req = accept && ((op == OP_FREE) || (op == OP_RELEASE && !rx_empty));
        a_idx         = (op == OP_FREE) ? sel_pnum : rx_head;
        auto_free_req = tx_done && tx_ok && auto_rel;
        done_push     = tx_done && !(tx_ok && auto_rel);
    end

    // Search step outcome.
    assign scan_done = (state == ST_SCAN) &&
                       (win_ok || !any_free || scan_idx == PAGE_W'(NUM_PAGES-1));
    assign commit    = (state == ST_SCAN) && win_ok && any_free;

    // Command sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    case (op)
                        OP_ALLOC:                                   state <= ST_SCAN;
                        OP_WIPE, OP_RELEASE, OP_FREE, OP_ENQUEUE:   state <= ST_HOLD;
                        default:                                    state <= ST_IDLE;
                    endcase
                end
                ST_SCAN: if (scan_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Search position and the latched request size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx <= '0;
            req_m1   <= '0;
        end else if (accept && op == OP_ALLOC) begin
            scan_idx <= '0;
            req_m1   <= cmd_arg;
        end else if (state == ST_SCAN) begin
            scan_idx <= scan_idx + 1'b1;
        end
    end

    // Result byte and the sticky allocation-done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_result <= '0;
            alloc_flag   <= 1'b0;
        end else begin
            if (commit)         alloc_result <= {1'b0, {PAD_W{1'b0}}, free_idx};
            else if (scan_done) alloc_result <= {1'b1, {(RES_W-1){1'b0}}};
            if (scan_done)       alloc_flag <= 1'b1;
            else if (irq_ack[0]) alloc_flag <= 1'b0;
        end
    end

    assign irq_stat = {!done_empty, alloc_flag};
    assign irq      = |(irq_stat & irq_mask);

    pba_page_map #(.NUM_PAGES(NUM_PAGES), .ARG_W(ARG_W), .PAGE_W(PAGE_W)) map_i (
        .clk(clk), .rst_n(rst_n), .clr(wipe),
        .scan_start(scan_idx), .cnt_m1(req_m1), .win_ok(win_ok), .commit(commit),
        .fa_en(host_free_req && a_valid), .fa_start(a_start), .fa_cnt(a_cnt),
        .fb_en(auto_free_req && b_valid), .fb_start(b_start), .fb_cnt(b_cnt)
    );

    pba_pnum_table #(.NPKT(NPKT), .PNUM_W(PNUM_W), .PAGE_W(PAGE_W), .ARG_W(ARG_W)) tbl_i (
        .clk(clk), .rst_n(rst_n), .clr(wipe),
        .any_free(any_free), .free_idx(free_idx),
        .a_idx(a_idx), .a_valid(a_valid), .a_start(a_start), .a_cnt(a_cnt),
        .b_idx(tx_done_pnum), .b_valid(b_valid), .b_start(b_start), .b_cnt(b_cnt),
        .set_en(commit), .set_idx(free_idx), .set_start(scan_idx), .set_cnt(req_m1),
        .ca_en(host_free_req && a_valid), .cb_en(auto_free_req && b_valid)
    );

    pba_fifo #(.DEPTH(FIFO_DEPTH), .W(PNUM_W)) txq_i (
        .clk(clk), .rst_n(rst_n), .clr(wipe), .push(enq_push), .din(sel_pnum),
        .pop(txq_pop), .dout(txq_head), .empty(txq_empty)
    );

    pba_fifo #(.DEPTH(FIFO_DEPTH), .W(PNUM_W)) rxq_i (
        .clk(clk), .rst_n(rst_n), .clr(wipe), .push(rx_push), .din(rx_pnum),
        .pop(rx_pop), .dout(rx_head), .empty(rx_empty)
    );

    pba_fifo #(.DEPTH(FIFO_DEPTH), .W(PNUM_W)) doneq_i (
        .clk(clk), .rst_n(rst_n), .clr(wipe), .push(done_push), .din(tx_done_pnum),
        .pop(irq_ack[1]), .dout(done_head), .empty(done_empty)
    );

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R3
    fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_result[RES_W-1] |-> (alloc_result[PNUM_W-1:0] == '0));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat[0] && !irq_ack[0]) |=> irq_stat[0]);

    // R2
    finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> (irq_stat[0] && !busy));
endmodule

// File: tb/pkt_buf_alloc_tb.sv
// Self-checking bench: directed corners, then seeded random command mix,
// compared against a page-level reference model kept in the bench.
module pkt_buf_alloc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 18;
    localparam int NK = 32;
    localparam int FD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [4:0] cmd_arg = '0;
    logic [4:0] sel_pnum = '0;
    logic       busy;
    logic [7:0] alloc_result;
    logic       auto_rel = 1'b0;
    logic [1:0] irq_mask = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq_stat;
    logic       irq;
    logic       txq_empty;
    logic [4:0] txq_head;
    logic       txq_pop = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_ok = 1'b0;
    logic [4:0] tx_done_pnum = '0;
    logic       done_empty;
    logic [4:0] done_head;
    logic       rx_push = 1'b0;
    logic [4:0] rx_pnum = '0;
    logic       rx_empty;
    logic [4:0] rx_head;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_buf_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .sel_pnum(sel_pnum), .busy(busy), .alloc_result(alloc_result),
        .auto_rel(auto_rel), .irq_mask(irq_mask), .irq_ack(irq_ack), .irq_stat(irq_stat),
        .irq(irq), .txq_empty(txq_empty), .txq_head(txq_head), .txq_pop(txq_pop),
        .tx_done(tx_done), .tx_ok(tx_ok), .tx_done_pnum(tx_done_pnum),
        .done_empty(done_empty), .done_head(done_head), .rx_push(rx_push),
        .rx_pnum(rx_pnum), .rx_empty(rx_empty), .rx_head(rx_head)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    // Reference model state
    bit  m_page [NP];
    bit  m_valid [NK];
    int  m_start [NK];
    int  m_len [NK];
    int  m_txq[$];
    int  m_rxq[$];
    int  m_doneq[$];
    bit  m_aflag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void m_clear();
        for (int i = 0; i < NP; i++) m_page[i] = 0;
        for (int i = 0; i < NK; i++) m_valid[i] = 0;
        m_txq.delete(); m_rxq.delete(); m_doneq.delete();
    endfunction

    function automatic void m_free(input int p);
        if (m_valid[p]) begin
            for (int i = m_start[p]; i < m_start[p] + m_len[p]; i++) m_page[i] = 0;
            m_valid[p] = 0;
        end
    endfunction

    // Expected result byte; updates the model on success.
    function automatic int m_alloc(input int arg);
        int n = arg + 1;
        int pn = -1;
        for (int i = NK-1; i >= 0; i--) if (!m_valid[i]) pn = i;
        if (pn < 0) return 8'h80;
        for (int s = 0; s + n <= NP; s++) begin
            bit freerun = 1;
            for (int i = s; i < s + n; i++) if (m_page[i]) freerun = 0;
            if (freerun) begin
                for (int i = s; i < s + n; i++) m_page[i] = 1;
                m_valid[pn] = 1; m_start[pn] = s; m_len[pn] = n;
                return pn;
            end
        end
        return 8'h80;
    endfunction

    task automatic check_all(input string req);
        bit [1:0] es;
        chk(txq_empty == (m_txq.size() == 0), req, txq_empty, m_txq.size() == 0);
        if (m_txq.size() != 0) chk(txq_head == m_txq[0], req, txq_head, m_txq[0]);
        chk(rx_empty == (m_rxq.size() == 0), req, rx_empty, m_rxq.size() == 0);
        if (m_rxq.size() != 0) chk(rx_head == m_rxq[0], req, rx_head, m_rxq[0]);
        chk(done_empty == (m_doneq.size() == 0), req, done_empty, m_doneq.size() == 0);
        if (m_doneq.size() != 0) chk(done_head == m_doneq[0], req, done_head, m_doneq[0]);
        es = {m_doneq.size() != 0, m_aflag};
        chk(irq_stat == es, "R5/R8", irq_stat, es);
        chk(irq == |(es & irq_mask), "R5", irq, |(es & irq_mask));
    endtask

    task automatic wait_idle();
        int w = 0;
        while (busy && w < 100) begin @(negedge clk); w++; end
        chk(!busy, "R4", busy, 0);
    endtask

    task automatic do_cmd(input int op, input int arg, input int sel);
        int exp;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 5'(arg); sel_pnum = 5'(sel);
        @(negedge clk);
        cmd_valid = 0;
        chk(busy == 1'b1, "R4", busy, 1);
        wait_idle();
        case (op)
            1: begin
                exp = m_alloc(arg);
                m_aflag = 1;
                chk(alloc_result == 8'(exp), (exp == 8'h80) ? "R3" : "R2", alloc_result, exp);
            end
            2: m_clear();
            3: if (m_rxq.size() != 0) begin m_free(m_rxq[0]); void'(m_rxq.pop_front()); end
            4: m_free(sel);
            5: if (m_txq.size() < FD) m_txq.push_back(sel);
            default: ;
        endcase
        check_all("R6/R7/R9/R10");
    endtask

    task automatic ack_alloc();
        @(negedge clk); irq_ack[0] = 1;
        @(negedge clk); irq_ack[0] = 0;
        m_aflag = 0;
        chk(irq_stat[0] == 1'b0, "R5", irq_stat[0], 0);
    endtask

    task automatic ack_done();
        @(negedge clk); irq_ack[1] = 1;
        @(negedge clk); irq_ack[1] = 0;
        if (m_doneq.size() != 0) void'(m_doneq.pop_front());
        check_all("R8");
    endtask

    task automatic tx_event(input int p, input bit ok);
        @(negedge clk); tx_done = 1; tx_ok = ok; tx_done_pnum = 5'(p);
        @(negedge clk); tx_done = 0;
        if (ok && auto_rel) m_free(p);
        else if (m_doneq.size() < FD) m_doneq.push_back(p);
        check_all("R8");
    endtask

    task automatic rx_event(input int p);
        @(negedge clk); rx_push = 1; rx_pnum = 5'(p);
        @(negedge clk); rx_push = 0;
        if (m_rxq.size() < FD) m_rxq.push_back(p);
        check_all("R11");
    endtask

    task automatic pop_tx();
        @(negedge clk); txq_pop = 1;
        @(negedge clk); txq_pop = 0;
        if (m_txq.size() != 0) void'(m_txq.pop_front());
        check_all("R7");
    endtask

    function automatic int pick_valid();
        int c[$];
        for (int i = 0; i < NK; i++) if (m_valid[i]) c.push_back(i);
        if (c.size() == 0) return int'($urandom_range(0, NK-1));
        return c[$urandom_range(0, c.size()-1)];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", busy, 0);
        chk(alloc_result == 0, "R1", alloc_result, 0);
        chk(irq_stat == 0 && irq == 0, "R1", irq_stat, 0);
        chk(txq_empty && rx_empty && done_empty, "R1", {txq_empty, rx_empty, done_empty}, 7);

        // R2 first-fit with a hole, lowest number reuse
        do_cmd(1, 0, 0); ack_alloc();   // pnum 0 at page 0
        do_cmd(1, 2, 0); ack_alloc();   // pnum 1 at pages 1..3
        do_cmd(4, 0, 0);                // R6 free pnum 0
        do_cmd(1, 1, 0);                // 2 pages: hole too small, expect pnum 0
        chk(irq_stat[0] == 1, "R2", irq_stat[0], 1);
        // R5 sticky and masking
        repeat (3) @(negedge clk);
        irq_mask = 2'b01; @(negedge clk);
        chk(irq == 1, "R5", irq, 1);
        irq_mask = 2'b00; @(negedge clk);
        chk(irq == 0, "R5", irq, 0);
        ack_alloc();
        do_cmd(4, 9, 9);                // R6 unused number: no effect
        do_cmd(1, 0, 0); ack_alloc();   // should land on page 0

        // R3 oversize fails; R4 command while busy ignored
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_arg = 5'd31;
        @(negedge clk);
        cmd_op = 3'd5; sel_pnum = 5'd3;   // enqueue while busy
        @(negedge clk);
        cmd_valid = 0;
        wait_idle();
        chk(alloc_result == 8'h80, "R3", alloc_result, 8'h80);
        chk(txq_empty == 1, "R4", txq_empty, 1);
        m_aflag = 1; ack_alloc();

        // R11 transmit queue overflow and order (R7)
        for (int i = 0; i < FD + 1; i++) do_cmd(5, 0, i + 10);
        for (int i = 0; i < FD + 1; i++) pop_tx();

        // R10 wipe, then whole memory in one allocation
        rx_event(4); do_cmd(5, 0, 2);
        do_cmd(2, 0, 0);
        do_cmd(1, 17, 0); ack_alloc();
        do_cmd(1, 0, 0); ack_alloc();   // R3 memory full
        // R9 release on empty FIFO, then real release
        do_cmd(3, 0, 0);
        rx_event(0); do_cmd(3, 0, 0);
        do_cmd(1, 0, 0); ack_alloc();
        // R8 auto release and completion path
        auto_rel = 1; tx_event(0, 1);
        do_cmd(1, 3, 0); ack_alloc();
        auto_rel = 0; tx_event(0, 1); tx_event(0, 0); ack_done(); ack_done();
        do_cmd(2, 0, 0);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int k = int'($urandom_range(0, 99));
            auto_rel = $urandom_range(0, 1);
            irq_mask = 2'($urandom_range(0, 3));
            if (k < 30)      begin do_cmd(1, int'($urandom_range(0, 6)), 0); ack_alloc(); end
            else if (k < 42) do_cmd(4, pick_valid(), pick_valid());
            else if (k < 52) do_cmd(5, 0, pick_valid());
            else if (k < 60) pop_tx();
            else if (k < 70) tx_event(pick_valid(), $urandom_range(0, 1));
            else if (k < 78) ack_done();
            else if (k < 87) rx_event(pick_valid());
            else if (k < 98) do_cmd(3, 0, 0);
            else             do_cmd(2, 0, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule